// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns a single column command into the run of column addresses a synchronous DRAM burst walks through. When a read or write column command is registered, the block captures the starting column, the burst length code, the ordering mode and the auto-precharge choice. From the next cycle on it presents one column per clock, together with a beat-valid flag, until the burst ends.

The block supports fixed bursts of 1, 2, 4 or 8 beats, which wrap inside the aligned block that holds the starting column, in linear or XOR ordering. It also supports a full-page burst that walks all columns modulo the page size and runs until it is stopped. A terminate input ends a burst at once. A new column command accepted on any clock restarts the burst from its own column.

A last-beat flag marks the final beat of a fixed burst. When auto precharge was requested at load, a precharge request is raised on that same beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first column command, beat_valid, last_beat and precharge_req are all low.
- R2: A column command sampled at a rising edge makes beat_valid high and col_out equal to the captured start_col from the following cycle on.
- R3: The burst length code len_sel is decoded as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The codes 4 to 6 give 1 beat. A fixed burst of N beats keeps beat_valid high for exactly N consecutive cycles.
- R4: When order_sel is 0 (linear), beat k of an N-beat fixed burst leaves the column bits above log2(N) unchanged. Its low log2(N) bits equal (start + k) mod N.
- R5: When order_sel is 1 (XOR), beat k of an N-beat fixed burst leaves the upper bits unchanged. Its low log2(N) bits equal start XOR k.
- R6: In full-page mode, beat k presents (start + k) mod 2^COL_W whatever order_sel is. The burst continues until a terminate or a new column command.
- R7: last_beat is high only on the final beat of a fixed burst, so a one-beat burst flags its only beat. last_beat is never high in full-page mode or while beat_valid is low.
- R8: With term high at a rising edge during a burst and no column command present, beat_valid and last_beat are low from the next cycle. term has no effect while no burst is active.
- R9: A column command during a burst restarts it from the new start_col with the new settings. A column command takes priority over term at the same edge.
- R10: precharge_req equals last_beat when auto_pre_en was high at the column command, and is low otherwise.
- R11: len_sel, order_sel and auto_pre_en are sampled only with a column command. Changes to them during a burst do not alter the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Column command registered this cycle |
| start_col | input | COL_W | Starting column of the burst |
| len_sel | input | 3 | Burst length code |
| order_sel | input | 1 | 0 linear, 1 XOR ordering |
| auto_pre_en | input | 1 | Request precharge at the end of the burst |
| term | input | 1 | Burst terminate |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final beat of a fixed burst |
| precharge_req | output | 1 | Start row precharge (last beat with auto precharge) |

## Verification
The hardest situation to reach from the ports is a burst whose settings change under it. The length code, order and auto-precharge inputs are all toggled while beats are still coming out, and in the same cycle a terminate or a second column command may collide with the last beat. The bench drives the inverse of every setting right after each load, over every start column, length and order. It then forces a command and a terminate into the same edge in mid-burst, and it runs full-page bursts past the column wrap from 511 to 0.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } burst_order_e;

   localparam int          LEN_CODE_W    = 3;
   localparam logic [2:0]  LEN_CODE_PAGE = 3'b111;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
   parameter int COL_W    = 9,
   parameter int MAX_LOG2 = 3
) (
   input  logic [burst_col_pkg::LEN_CODE_W-1:0] len_code,
   output logic [COL_W-1:0]                     beat_mask,
   output logic                                 full_page
);
   import burst_col_pkg::*;

   localparam int NCODES = MAX_LOG2 + 1;

   logic [NCODES-1:0]            hit;
   logic [NCODES-1:0][COL_W-1:0] mask_tab;

   generate
      for (genvar c = 0; c < NCODES; c++) begin : g_code
         assign hit[c]      = (len_code == LEN_CODE_W'(c));
         assign mask_tab[c] = COL_W'((1 << c) - 1);
      end
   endgenerate

   always_comb begin
      full_page = (len_code == LEN_CODE_PAGE);
      beat_mask = '0;
      if (full_page) begin
         beat_mask = '1;
      end else begin
         for (int c = 0; c < NCODES; c++) begin
            if (hit[c]) beat_mask = mask_tab[c];
         end
      end
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             term,
   input  logic             full_page,
   input  logic [COL_W-1:0] beat_mask,
   output logic             active,
   output logic [COL_W-1:0] beat_cnt,
   output logic             final_beat
);

   assign final_beat = active && !full_page && (beat_cnt == beat_mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         beat_cnt <= '0;
      end else if (load) begin
         active   <= 1'b1;
         beat_cnt <= '0;
      end else if (active) begin
         if (term || final_beat) begin
            active   <= 1'b0;
            beat_cnt <= '0;
         end else begin
            beat_cnt <= beat_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
   parameter int COL_W = 9
) (
   input  logic             xor_order,
   input  logic             full_page,
   input  logic [COL_W-1:0] base_col,
   input  logic [COL_W-1:0] beat_cnt,
   input  logic [COL_W-1:0] beat_mask,
   output logic [COL_W-1:0] col
);

   logic [COL_W-1:0] lin_sum;
   logic [COL_W-1:0] xor_mix;
   logic             use_xor;

   assign lin_sum = base_col + beat_cnt;
   assign xor_mix = base_col ^ beat_cnt;
   assign use_xor = xor_order && !full_page;

   generate
      for (genvar b = 0; b < COL_W; b++) begin : g_bit
         always_comb begin
            if (!beat_mask[b])  col[b] = base_col[b];
            else if (use_xor)   col[b] = xor_mix[b];
            else                col[b] = lin_sum[b];
         end
      end
   endgenerate

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int COL_W    = 9,
   parameter int MAX_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_load,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       len_sel,
   input  logic             order_sel,
   input  logic             auto_pre_en,
   input  logic             term,
   output logic [COL_W-1:0] col_out,
   output logic             beat_valid,
   output logic             last_beat,
   output logic             precharge_req
);
   import burst_col_pkg::*;

   generate
      if (COL_W <= MAX_LOG2) begin : g_bad_width
         $error("burst_col_gen: COL_W must exceed MAX_LOG2");
      end
      if (MAX_LOG2 < 0 || MAX_LOG2 > 6) begin : g_bad_log2
         $error("burst_col_gen: MAX_LOG2 out of range");
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_full;

   logic [COL_W-1:0] start_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   burst_order_e     order_q;
   logic             ap_q;

   logic [COL_W-1:0] beat_cnt;
   logic             active;
   logic             final_beat;

   burst_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_dec (
      .len_code  (len_sel),
      .beat_mask (dec_mask),
      .full_page (dec_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         order_q <= ORD_LINEAR;
         ap_q    <= 1'b0;
      end else if (cmd_load) begin
         start_q <= start_col;
         mask_q  <= dec_mask;
         full_q  <= dec_full;
         order_q <= burst_order_e'(order_sel);
         ap_q    <= auto_pre_en;
      end
   end

   burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmd_load),
      .term       (term),
      .full_page  (full_q),
      .beat_mask  (mask_q),
      .active     (active),
      .beat_cnt   (beat_cnt),
      .final_beat (final_beat)
   );

   burst_col_map #(.COL_W(COL_W)) u_map (
      .xor_order (order_q == ORD_XOR),
      .full_page (full_q),
      .base_col  (start_q),
      .beat_cnt  (beat_cnt),
      .beat_mask (mask_q),
      .col       (col_out)
   );

   assign beat_valid    = active;
   assign last_beat     = final_beat;
   assign precharge_req = final_beat && ap_q;

endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_load,
   input logic [COL_W-1:0] start_col,
   input logic [2:0]       len_sel,
   input logic             term,
   input logic [COL_W-1:0] col_out,
   input logic             beat_valid,
   input logic             last_beat,
   input logic             precharge_req,
   input logic             full_q
);

   logic [COL_W-1:0] col_next;
   assign col_next = col_out + 1'b1;

   p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_load |=> (beat_valid && col_out == $past(start_col)));

   p_one_beat_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load && len_sel == 3'd0) |=> last_beat);

   p_last_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> beat_valid);

   p_full_no_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && full_q) |-> !last_beat);

   p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !cmd_load) |=> !beat_valid);

   p_term_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && term && !cmd_load) |=> (!beat_valid && !last_beat));

   p_full_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && full_q && !term && !cmd_load) |=> (col_out == $past(col_next)));

   p_precharge_r10: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_req |-> last_beat);

endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_burst_col_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_load      (cmd_load),
   .start_col     (start_col),
   .len_sel       (len_sel),
   .term          (term),
   .col_out       (col_out),
   .beat_valid    (beat_valid),
   .last_beat     (last_beat),
   .precharge_req (precharge_req),
   .full_q        (full_q)
);

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;

   localparam int COL_W = 9;
   localparam int PAGE  = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cmd_load;
   logic [COL_W-1:0] start_col;
   logic [2:0]       len_sel;
   logic             order_sel;
   logic             auto_pre_en;
   logic             term;
   logic [COL_W-1:0] col_out;
   logic             beat_valid;
   logic             last_beat;
   logic             precharge_req;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   burst_col_gen #(.COL_W(COL_W), .MAX_LOG2(3)) i_burst_col_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_load      (cmd_load),
      .start_col     (start_col),
      .len_sel       (len_sel),
      .order_sel     (order_sel),
      .auto_pre_en   (auto_pre_en),
      .term          (term),
      .col_out       (col_out),
      .beat_valid    (beat_valid),
      .last_beat     (last_beat),
      .precharge_req (precharge_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_col(input int s, input int k, input int n, input int ord);
      int m;
      m = n - 1;
      if (ord == 1) return (s & ~m & (PAGE - 1)) | ((s ^ k) & m);
      return (s & ~m & (PAGE - 1)) | ((s + k) & m);
   endfunction

   task automatic load(input int s, input int code, input int ord, input int ap);
      @(negedge clk);
      cmd_load    = 1'b1;
      start_col   = COL_W'(s);
      len_sel     = 3'(code);
      order_sel   = ord[0];
      auto_pre_en = ap[0];
      @(negedge clk);
      cmd_load    = 1'b0;
      len_sel     = ~len_sel;       // R11: disturb settings mid-burst
      order_sel   = ~order_sel;
      auto_pre_en = ~auto_pre_en;
   endtask

   task automatic fixed_burst(input int s, input int code, input int ord, input int ap, input int n);
      load(s, code, ord, ap);
      for (int k = 0; k < n; k++) begin
         chk("R3 valid", int'(beat_valid), 1);
         if (n > 1) chk(ord == 1 ? "R5 col" : "R4 col", int'(col_out), exp_col(s, k, n, ord));
         else       chk("R2 col", int'(col_out), s);
         chk("R7 last", int'(last_beat), int'(k == n - 1));
         chk("R10 precharge", int'(precharge_req), int'(k == n - 1 && ap == 1));
         @(negedge clk);
      end
      chk("R3 end", int'(beat_valid), 0);
   endtask

   initial begin
      rst_n = 1'b0; cmd_load = 1'b0; start_col = '0; len_sel = '0;
      order_sel = 1'b0; auto_pre_en = 1'b0; term = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 valid", int'(beat_valid), 0);
      chk("R1 last", int'(last_beat), 0);
      chk("R1 precharge", int'(precharge_req), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle", int'(beat_valid), 0);

      // R8: term while idle has no effect
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R8 idle term", int'(beat_valid), 0);

      // R3 R4 R5 R7 R10 R11: sweep every start, fixed length and order
      for (int code = 0; code < 4; code++)
         for (int ord = 0; ord < 2; ord++)
            for (int s = 0; s < PAGE; s++)
               fixed_burst(s, code, ord, (s >> 1) & 1, 1 << code);

      // R3: reserved codes give one beat
      for (int code = 4; code < 7; code++) fixed_burst(37 * code, code, 1, 1, 1);

      // R6: full page from several starts, wrapping past the top
      for (int t = 0; t < 3; t++) begin
         int s;
         s = (t == 0) ? 0 : (t == 1) ? PAGE - 1 : 300;
         load(s, 7, t & 1, 1);
         for (int k = 0; k < PAGE + 8; k++) begin
            chk("R6 col", int'(col_out), (s + k) % PAGE);
            chk("R7 full no last", int'(last_beat), 0);
            chk("R10 full no precharge", int'(precharge_req), 0);
            if (k == PAGE + 7) term = 1'b1;
            @(negedge clk);
         end
         term = 1'b0;
         chk("R8 full term", int'(beat_valid), 0);
      end

      // R8: terminate an 8-beat burst at beat 3
      load(16, 3, 0, 1);
      repeat (3) @(negedge clk);
      chk("R8 pre-term col", int'(col_out), 19);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk("R8 stopped", int'(beat_valid), 0);
      chk("R8 no last", int'(last_beat), 0);
      chk("R8 no precharge", int'(precharge_req), 0);

      // R9: new command with term at the same edge mid-burst
      load(5, 3, 0, 0);
      @(negedge clk);
      chk("R9 before", int'(col_out), 6);
      cmd_load = 1'b1; term = 1'b1; start_col = 9'd102; len_sel = 3'd2;
      order_sel = 1'b1; auto_pre_en = 1'b1;
      @(negedge clk);
      cmd_load = 1'b0; term = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk("R9 valid", int'(beat_valid), 1);
         chk("R9 col", int'(col_out), exp_col(102, k, 4, 1));
         chk("R9 last", int'(last_beat), int'(k == 3));
         chk("R9 precharge", int'(precharge_req), int'(k == 3));
         @(negedge clk);
      end
      chk("R9 end", int'(beat_valid), 0);

      // R9: back-to-back commands on consecutive edges
      @(negedge clk);
      cmd_load = 1'b1; start_col = 9'd200; len_sel = 3'd3; order_sel = 1'b0;
      @(negedge clk);
      start_col = 9'd400; len_sel = 3'd1;
      @(negedge clk);
      cmd_load = 1'b0;
      chk("R9 restart col", int'(col_out), 400);
      @(negedge clk);
      chk("R9 restart col2", int'(col_out), 401);
      chk("R9 restart last", int'(last_beat), 1);
      @(negedge clk);
      chk("R9 restart end", int'(beat_valid), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule